// File: doc/BRIEF.md
# Scaled Integer to Single-Precision Float Converter

This block turns a 32-bit integer into an IEEE-754 single-precision number in one registered stage. A per-operation select says whether the operand is read as a two's-complement signed value or as an unsigned value. After conversion the result is divided by 2^t, where t is a 4-bit immediate. This turns a fixed-point integer with t fraction bits into its floating-point value.

When the integer needs more than 24 significant bits, the result is rounded to the 24-bit significand. The rounding follows a dynamic 2-bit rounding-mode input that is sampled along with the operand. A result appears one clock after its valid strobe. While no operation is issued, the output register keeps its last value.

Top module: `scaled_int2fp_conv`

## Requirements
- R1: While rst_n is low, out_vld and out_val are driven to 0.
- R2: out_vld equals the in_vld of the previous clock, so each result arrives exactly one cycle after its operation is issued.
- R3: When cvt_unsigned is 0, in_data is read as two's-complement signed. A negative operand produces a result with sign bit 31 set and the magnitude of its absolute value.
- R4: When cvt_unsigned is 1, in_data is read as unsigned. Every nonzero result then has sign bit 31 clear, including operands with bit 31 set.
- R5: An in_data of zero gives +0.0 (0x00000000) for both signedness selects, every rounding mode and every scale.
- R6: Operands whose magnitude is below 2^24 convert exactly, whatever the rounding mode.
- R7: With rmode 0 (nearest-even), inexact magnitudes round to the nearest representable value. Exact ties go to the value whose significand is even. A round-up that carries past the significand increments the exponent.
- R8: With rmode 1 (toward zero), inexact magnitudes are truncated.
- R9: With rmode 2 (toward plus infinity), an inexact positive value rounds up in magnitude and an inexact negative value is truncated.
- R10: With rmode 3 (toward minus infinity), an inexact negative value rounds up in magnitude and an inexact positive value is truncated.
- R11: The result equals the converted integer times 2^-t, with t = in_scale (0 to 15). The scale only lowers the biased exponent, and no underflow occurs.
- R12: The signed operand 0x80000000 converts exactly to -2^31 (0xCF000000 when t is 0).
- R13: While in_vld is low, out_val keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation issue strobe |
| cvt_unsigned | input | 1 | 0: signed operand, 1: unsigned operand |
| in_scale | input | 4 | Fraction bit count t; the result is scaled by 2^-t |
| in_rmode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| in_data | input | 32 | Integer operand |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_val | output | 32 | Single-precision result |

## Verification
The checker assumes that all inputs carry known values at every rising edge, including cycles where in_vld is low. It also assumes that rst_n is asserted before the first operation. The bench keeps to this: it drives every input at the falling edge, gives each input a defined value in every cycle, and releases reset only after several clocks. The stimulus combines directed ties and carries near 2^24 and 2^32 with random operands, scales, modes and issue gaps. These gaps exercise the hold behaviour.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'd0,
      RM_TO_ZERO   = 2'd1,
      RM_TO_POS    = 2'd2,
      RM_TO_NEG    = 2'd3
   } rmode_e;
endpackage

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
   parameter int INT_W = 32,
   localparam int POS_W = $clog2(INT_W)
) (
   input  logic [INT_W-1:0] mag_i,
   output logic [INT_W-1:0] norm_o,
   output logic [POS_W-1:0] msb_o
);
   always_comb begin
      msb_o = '0;
      for (int i = 0; i < INT_W; i++) begin
         if (mag_i[i]) msb_o = POS_W'(i);
      end
   end

   assign norm_o = mag_i << (POS_W'(INT_W - 1) - msb_o);
endmodule

// File: rtl/i2f_round.sv
module i2f_round
   import i2f_pkg::*;
#(
   parameter int INT_W = 32,
   parameter int MAN_W = 23,
   localparam int SIG_W = MAN_W + 1,
   localparam int LOW_W = INT_W - SIG_W
) (
   input  logic [INT_W-1:0] norm_i,
   input  logic             neg_i,
   input  logic [1:0]       rmode_i,
   output logic [MAN_W-1:0] frac_o,
   output logic             carry_o
);
   logic [SIG_W-1:0] kept;
   logic             half;
   logic             sticky;
   logic             inexact;
   logic             inc;
   logic [SIG_W:0]   sum;

   assign kept = norm_i[INT_W-1 -: SIG_W];
   assign half = norm_i[LOW_W-1];

   generate
      if (LOW_W > 1) begin : g_sticky
         assign sticky = |norm_i[LOW_W-2:0];
      end else begin : g_no_sticky
         assign sticky = 1'b0;
      end
   endgenerate

   assign inexact = half | sticky;

   always_comb begin
      case (rmode_e'(rmode_i))
         RM_NEAR_EVEN: inc = half & (sticky | kept[0]);
         RM_TO_ZERO:   inc = 1'b0;
         RM_TO_POS:    inc = inexact & ~neg_i;
         default:      inc = inexact & neg_i;
      endcase
   end

   assign sum     = {1'b0, kept} + (SIG_W + 1)'(inc);
   assign carry_o = sum[SIG_W];
   assign frac_o  = sum[MAN_W-1:0];
endmodule

// File: rtl/scaled_int2fp_conv.sv
module scaled_int2fp_conv #(
   parameter int INT_W   = 32,
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int SCALE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic                     cvt_unsigned,
   input  logic [SCALE_W-1:0]       in_scale,
   input  logic [1:0]               in_rmode,
   input  logic [INT_W-1:0]         in_data,
   output logic                     out_vld,
   output logic [EXP_W+MAN_W:0]     out_val
);
   localparam int FP_W  = EXP_W + MAN_W + 1;
   localparam int POS_W = $clog2(INT_W);
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int EW    = EXP_W + 2;

   generate
      if (INT_W < MAN_W + 3) begin : g_bad_width
         $error("INT_W must exceed the significand by at least two bits");
      end
      if (BIAS <= (1 << SCALE_W) - 1) begin : g_bad_scale
         $error("scale range could underflow the exponent");
      end
      if (BIAS + INT_W >= (1 << EXP_W) - 1) begin : g_bad_exp
         $error("exponent field too narrow for the integer width");
      end
   endgenerate

   logic             neg;
   logic [INT_W-1:0] mag;
   logic [INT_W-1:0] norm;
   logic [POS_W-1:0] msb;
   logic [MAN_W-1:0] frac;
   logic             carry;
   logic [EW-1:0]    exp_full;
   logic [FP_W-1:0]  result;

   assign neg = ~cvt_unsigned & in_data[INT_W-1];
   assign mag = neg ? (~in_data + INT_W'(1)) : in_data;

   i2f_normalize #(.INT_W(INT_W)) norm_i (
      .mag_i  (mag),
      .norm_o (norm),
      .msb_o  (msb)
   );

   i2f_round #(.INT_W(INT_W), .MAN_W(MAN_W)) rnd_i (
      .norm_i  (norm),
      .neg_i   (neg),
      .rmode_i (in_rmode),
      .frac_o  (frac),
      .carry_o (carry)
   );

   assign exp_full = EW'(BIAS) + EW'(msb) + EW'(carry) - EW'(in_scale);
   assign result   = (mag == '0) ? '0 : {neg, exp_full[EXP_W-1:0], frac};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_val <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_val <= result;
      end
   end
endmodule

// File: rtl/i2f_chk.sv
module i2f_chk #(
   parameter int INT_W   = 32,
   parameter int FP_W    = 32,
   parameter int SCALE_W = 4,
   parameter int MAN_W   = 23
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_vld,
   input logic               cvt_unsigned,
   input logic [SCALE_W-1:0] in_scale,
   input logic [INT_W-1:0]   in_data,
   input logic               out_vld,
   input logic [FP_W-1:0]    out_val
);
   localparam int EXP_W = FP_W - MAN_W - 1;
   localparam int MIN_E = (1 << (EXP_W - 1)) - 1 - ((1 << SCALE_W) - 1);

   // R2
   issue_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   // R2
   idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
   // R13
   hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_val));
   // R5
   zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_data == '0) |=> (out_val == '0));
   // R3
   signed_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !cvt_unsigned && in_data[INT_W-1]) |=> out_val[FP_W-1]);
   // R4
   unsigned_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cvt_unsigned) |=> !out_val[FP_W-1]);
   // R11
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_data != '0) |=> (int'(out_val[FP_W-2:MAN_W]) >= MIN_E));
endmodule

bind scaled_int2fp_conv i2f_chk #(
   .INT_W(INT_W), .FP_W(EXP_W + MAN_W + 1), .SCALE_W(SCALE_W), .MAN_W(MAN_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cvt_unsigned(cvt_unsigned),
   .in_scale(in_scale), .in_data(in_data), .out_vld(out_vld), .out_val(out_val)
);

// File: tb/scaled_int2fp_conv_tb.sv
`timescale 1ns/1ps
module scaled_int2fp_conv_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic        cvt_unsigned = 1'b0;
   logic [3:0]  in_scale = '0;
   logic [1:0]  in_rmode = '0;
   logic [31:0] in_data = '0;
   logic        out_vld;
   logic [31:0] out_val;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [31:0] exp_val = '0;
   logic        exp_vld = 1'b0;
   string       exp_tag = "R1";

   always #2.5 clk = ~clk;

   scaled_int2fp_conv dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cvt_unsigned(cvt_unsigned),
      .in_scale(in_scale), .in_rmode(in_rmode), .in_data(in_data),
      .out_vld(out_vld), .out_val(out_val)
   );

   function automatic logic [31:0] ref_cvt(bit uns, logic [31:0] d, int t, int rm);
      longint m;
      longint q;
      longint rem;
      longint half;
      bit     neg;
      bit     inc;
      int     p;
      int     sh;
      int     e;
      neg = !uns && d[31];
      m = longint'({32'b0, d});
      if (neg) m = 64'sd4294967296 - m;
      if (m == 0) return 32'h0;
      p = 0;
      for (int i = 0; i < 33; i++) if ((m >> i) != 0) p = i;
      if (p <= 23) begin
         q = m << (23 - p);
         rem = 0;
         half = 1;
      end else begin
         sh = p - 23;
         q = m >> sh;
         rem = m - (q << sh);
         half = longint'(1) << (sh - 1);
      end
      case (rm)
         0: inc = (rem > half) || (rem == half && rem != 0 && q[0]);
         1: inc = 1'b0;
         2: inc = !neg && rem != 0;
         default: inc = neg && rem != 0;
      endcase
      q = q + longint'(inc);
      e = p;
      if (q == (longint'(1) << 24)) begin
         q = longint'(1) << 23;
         e = e + 1;
      end
      return {neg, 8'(127 + e - t), q[22:0]};
   endfunction

   task automatic check_now();
      checks++;
      if (out_vld !== exp_vld) begin
         errors++;
         $display("FAIL R2 (%s): out_vld actual %0b expected %0b", exp_tag, out_vld, exp_vld);
      end
      checks++;
      if (out_val !== exp_val) begin
         errors++;
         $display("FAIL %s: out_val actual %h expected %h", exp_tag, out_val, exp_val);
      end
   endtask

   task automatic step(bit v, bit uns, int t, int rm, logic [31:0] d, string tag);
      @(negedge clk);
      check_now();
      in_vld = v;
      cvt_unsigned = uns;
      in_scale = 4'(t);
      in_rmode = 2'(rm);
      in_data = d;
      exp_vld = v;
      if (v) exp_val = ref_cvt(uns, d, t, rm);
      exp_tag = tag;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_vld !== 1'b0 || out_val !== 32'h0) begin
         errors++;
         $display("FAIL R1: actual vld %0b val %h expected 0 0", out_vld, out_val);
      end
      rst_n = 1'b1;
      exp_tag = "R1";
      // R5 zero for both selects
      step(1, 0, 0, 1, 32'h0, "R5 signed zero");
      step(1, 1, 15, 3, 32'h0, "R5 unsigned zero");
      // R6 exact small values
      step(1, 0, 0, 0, 32'h1, "R6 one");
      step(1, 0, 0, 2, 32'h00FFFFFF, "R6 max exact");
      // R3 signed negative
      step(1, 0, 0, 0, 32'hFFFFFFFF, "R3 minus one");
      // R4 unsigned with msb set
      step(1, 1, 0, 1, 32'hFFFFFFFF, "R4 all ones");
      // R7 ties and carry
      step(1, 0, 0, 0, 32'h01000001, "R7 tie to even down");
      step(1, 0, 0, 0, 32'h01000003, "R7 tie to even up");
      step(1, 1, 0, 0, 32'hFFFFFFFF, "R7 carry into exponent");
      // R8 / R9 / R10 with both signs
      step(1, 0, 0, 1, 32'h01000003, "R8 positive truncate");
      step(1, 0, 0, 1, 32'hFEFFFFFD, "R8 negative truncate");
      step(1, 0, 0, 2, 32'h01000001, "R9 positive up");
      step(1, 0, 0, 2, 32'hFEFFFFFF, "R9 negative truncate");
      step(1, 0, 0, 3, 32'hFEFFFFFF, "R10 negative up");
      step(1, 0, 0, 3, 32'h01000001, "R10 positive truncate");
      // R12 most negative signed
      step(1, 0, 0, 0, 32'h80000000, "R12 min signed");
      step(1, 0, 5, 2, 32'h80000000, "R12 min signed scaled");
      // R11 scaling
      step(1, 0, 15, 0, 32'h1, "R11 smallest scaled");
      step(1, 1, 8, 0, 32'h00000180, "R11 fixed point 1.5");
      // R13 hold while idle
      step(0, 1, 3, 2, 32'h12345678, "R13 idle hold");
      step(0, 0, 0, 0, 32'h0, "R13 idle hold zero data");
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] d;
         d = $urandom;
         if (i % 3 == 0) d = d >> ($urandom % 32);
         step(($urandom % 4) != 0, $urandom % 2, $urandom % 16, $urandom % 4, d,
              "R11 R13 random");
      end
      step(0, 0, 0, 0, 32'h0, "R13 drain");
      @(negedge clk);
      check_now();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule